// File: doc/BRIEF.md
# Packed SIMD Saturating ALU

This block is a registered datapath that treats each 64-bit operand as a row of packed sub-words. A per-operation element-size code splits the word into eight 8-bit, four 16-bit or two 32-bit lanes. Every lane is processed at the same time and on its own. Add and subtract come in three flavours: wrapping, signed saturating and unsigned saturating. Lane-wise equal and signed greater-than compares turn each lane into a mask of all ones or all zeros. Four bitwise operations act on the whole word.

A single adder array, built from byte slices, is cut at runtime at the lane boundaries. Compares reuse the subtractor path. The result is captured in an output register together with a valid flag, one cycle after the operation is presented.

Top module: `simd_sat_alu`

## Requirements
- R1: `esz_i` selects the lane size: 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, and 2 or 3 give two 32-bit lanes. Lane k occupies bits [k*w +: w]. No carry or borrow passes from one lane into the next.
- R2: Opcode 0 gives a wrapping add and opcode 1 gives a wrapping subtract (a minus b). Each lane result is modulo 2^w.
- R3: Opcode 2 (signed saturating add) and opcode 3 (signed saturating subtract) clamp a lane that overflows. Positive overflow gives 2^(w-1)-1 and negative overflow gives -2^(w-1).
- R4: Opcode 4 (unsigned saturating add) clamps overflow to all ones. Opcode 5 (unsigned saturating subtract) clamps underflow to zero.
- R5: Opcodes 6, 7, 8 and 9 give, in that order: a AND b, (NOT a) AND b, a OR b, and a XOR b. They act on all 64 bits regardless of `esz_i`.
- R6: Opcode 10 (equal) and opcode 11 (signed a greater than b) write all ones to a lane when the test is true and all zeros when it is false.
- R7: Opcodes 12 to 15 produce a zero result.
- R8: `res_o` and `valid_o` reflect an operation presented with `valid_i` high on the following clock edge. `valid_o` is low after any edge at which `valid_i` was low.
- R9: `res_o` keeps its value across an edge at which `valid_i` is low.
- R10: While `rst_ni` is low, `valid_o` and `res_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Opcode |
| esz_i | input | 2 | Lane size code |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| valid_o | output | 1 | Result register holds a fresh result |
| res_o | output | 64 | Registered result |

## Verification
A broken lane cut in the segmented adder makes a carry or borrow leak into the neighbouring lane. This shows at `res_o` one cycle later on any operand whose lane overflows, so the bench mixes directed boundary vectors (0xFF..., 0x7F..., 0x80...) with random words and all four size codes. A saturation decision taken from the wrong byte of a lane, or a wrong sign flag, appears as a clamp value in the lower bytes or a lane that wraps instead of clamping. A compare that is evaluated per byte instead of per lane appears as a lane that is not uniform. All of these faults show on the first affected operation, and every result is compared against a lane model in the bench.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam logic [3:0] OP_ADD   = 4'd0;
  localparam logic [3:0] OP_SUB   = 4'd1;
  localparam logic [3:0] OP_ADDS  = 4'd2;
  localparam logic [3:0] OP_SUBS  = 4'd3;
  localparam logic [3:0] OP_ADDU  = 4'd4;
  localparam logic [3:0] OP_SUBU  = 4'd5;
  localparam logic [3:0] OP_AND   = 4'd6;
  localparam logic [3:0] OP_ANDN  = 4'd7;
  localparam logic [3:0] OP_OR    = 4'd8;
  localparam logic [3:0] OP_XOR   = 4'd9;
  localparam logic [3:0] OP_CMPEQ = 4'd10;
  localparam logic [3:0] OP_CMPGT = 4'd11;

  // byte-index mask inside one lane: lane top byte = k | span
  function automatic logic [2:0] lane_span(logic [1:0] esz);
    case (esz)
      2'd0:    return 3'd0;
      2'd1:    return 3'd1;
      default: return 3'd3;
    endcase
  endfunction
endpackage

// File: rtl/simd_seg_adder.sv
module simd_seg_adder #(
  parameter int NB = 8,
  localparam int IW = $clog2(NB),
  localparam int DW = NB * 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  input  logic [IW-1:0] span_i,
  output logic [DW-1:0] sum_o,
  output logic [NB-1:0] cout_o,
  output logic [NB-1:0] ovf_o
);
  logic       c;
  logic [7:0] bx;
  logic [8:0] t;

  always_comb begin
    c = 1'b0;
    bx = '0;
    t = '0;
    for (int k = 0; k < NB; k++) begin
      bx = b_i[8*k +: 8] ^ {8{sub_i}};
      if ((IW'(k) & span_i) == '0) c = sub_i;  // lane start: cut the chain
      t = {1'b0, a_i[8*k +: 8]} + {1'b0, bx} + {8'd0, c};
      c = t[8];
      sum_o[8*k +: 8] = t[7:0];
      cout_o[k] = t[8];
      ovf_o[k] = (a_i[8*k+7] == bx[7]) && (t[7] != a_i[8*k+7]);
    end
  end

  always_comb begin
    for (int k = 0; k < NB; k++) begin
      // R1
      if ((IW'(k) & span_i) == '0 && b_i[8*k +: 8] == 8'd0)
        lane_iso_chk: assert (sum_o[8*k +: 8] == a_i[8*k +: 8])
          else $error("lane start byte %0d took a foreign carry", k);
    end
  end
endmodule

// File: rtl/simd_lane_sat.sv
module simd_lane_sat #(
  parameter int NB = 8,
  localparam int IW = $clog2(NB),
  localparam int DW = NB * 8
) (
  input  logic [DW-1:0] sum_i,
  input  logic [NB-1:0] cout_i,
  input  logic [NB-1:0] ovf_i,
  input  logic [NB-1:0] a_msb_i,
  input  logic [IW-1:0] span_i,
  input  logic          sub_i,
  input  logic          sat_sgn_i,
  input  logic          sat_uns_i,
  output logic [DW-1:0] res_o
);
  logic [IW-1:0] top;
  logic          neg;

  always_comb begin
    top = '0;
    neg = 1'b0;
    for (int k = 0; k < NB; k++) begin
      top = IW'(k) | span_i;
      neg = a_msb_i[top];
      res_o[8*k +: 8] = sum_i[8*k +: 8];
      if (sat_sgn_i && ovf_i[top]) begin
        if (top == IW'(k)) res_o[8*k +: 8] = neg ? 8'h80 : 8'h7f;
        else               res_o[8*k +: 8] = neg ? 8'h00 : 8'hff;
      end else if (sat_uns_i && (sub_i ? !cout_i[top] : cout_i[top])) begin
        res_o[8*k +: 8] = sub_i ? 8'h00 : 8'hff;
      end
    end
  end
endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp #(
  parameter int NB = 8,
  localparam int IW = $clog2(NB),
  localparam int DW = NB * 8
) (
  input  logic [DW-1:0] diff_i,
  input  logic [NB-1:0] ovf_i,
  input  logic [IW-1:0] span_i,
  input  logic          gt_sel_i,
  output logic [DW-1:0] mask_o
);
  logic [NB-1:0] zb;
  logic [IW-1:0] top;
  logic          eq, lt, hit;

  always_comb begin
    for (int j = 0; j < NB; j++) zb[j] = (diff_i[8*j +: 8] == 8'd0);
    top = '0;
    eq = 1'b0;
    lt = 1'b0;
    hit = 1'b0;
    for (int k = 0; k < NB; k++) begin
      top = IW'(k) | span_i;
      eq = 1'b1;
      for (int j = 0; j < NB; j++)
        if ((IW'(j) | span_i) == top) eq = eq & zb[j];
      lt = diff_i[8*top+7] ^ ovf_i[top];  // sign of a-b corrected by overflow
      hit = gt_sel_i ? (!lt && !eq) : eq;
      mask_o[8*k +: 8] = {8{hit}};
    end
  end
endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int NB = DATA_W / 8,
  localparam int IW = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        esz_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res_o
);
  logic [IW-1:0]     span;
  logic              sub, sat_sgn, sat_uns;
  logic [DATA_W-1:0] sum, sat_res, cmp_res, res_d;
  logic [NB-1:0]     cout, ovf, a_msb;

  assign span    = IW'(lane_span(esz_i));
  assign sub     = (op_i == OP_SUB) || (op_i == OP_SUBS) || (op_i == OP_SUBU) ||
                   (op_i == OP_CMPEQ) || (op_i == OP_CMPGT);
  assign sat_sgn = (op_i == OP_ADDS) || (op_i == OP_SUBS);
  assign sat_uns = (op_i == OP_ADDU) || (op_i == OP_SUBU);

  for (genvar k = 0; k < NB; k++) begin : g_msb
    assign a_msb[k] = a_i[8*k+7];
  end

  simd_seg_adder #(.NB(NB)) u_add (
    .a_i(a_i), .b_i(b_i), .sub_i(sub), .span_i(span),
    .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
  );

  simd_lane_sat #(.NB(NB)) u_sat (
    .sum_i(sum), .cout_i(cout), .ovf_i(ovf), .a_msb_i(a_msb), .span_i(span),
    .sub_i(sub), .sat_sgn_i(sat_sgn), .sat_uns_i(sat_uns), .res_o(sat_res)
  );

  simd_lane_cmp #(.NB(NB)) u_cmp (
    .diff_i(sum), .ovf_i(ovf), .span_i(span),
    .gt_sel_i(op_i == OP_CMPGT), .mask_o(cmp_res)
  );

  always_comb begin
    case (op_i)
      OP_ADD, OP_SUB, OP_ADDS, OP_SUBS, OP_ADDU, OP_SUBU: res_d = sat_res;
      OP_AND:             res_d = a_i & b_i;
      OP_ANDN:            res_d = ~a_i & b_i;
      OP_OR:              res_d = a_i | b_i;
      OP_XOR:             res_d = a_i ^ b_i;
      OP_CMPEQ, OP_CMPGT: res_d = cmp_res;
      default:            res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= res_d;
    end
  end

  always_comb begin
    if (rst_ni) begin
      for (int k = 0; k < NB; k++) begin
        // R6
        if (op_i == OP_CMPEQ || op_i == OP_CMPGT)
          cmp_lane_chk: assert (res_d[8*k +: 8] == res_d[8*(IW'(k) | span) +: 8])
            else $error("compare lane not uniform at byte %0d", k);
        // R4
        if (op_i == OP_ADDU && esz_i == 2'd0)
          addu_floor_chk: assert (res_d[8*k +: 8] >= a_i[8*k +: 8])
            else $error("unsigned saturating add fell below operand");
        // R3
        if (op_i == OP_ADDS && esz_i == 2'd0 && a_i[8*k+7] == b_i[8*k+7])
          adds_sign_chk: assert (res_d[8*k+7] == a_i[8*k+7])
            else $error("signed saturating add flipped sign");
      end
    end
  end

  // R8
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R8
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R9
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));
endmodule

// File: tb/tb_simd_sat_alu.sv
`timescale 1ns/1ps
module tb_simd_sat_alu;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [1:0]  esz_i = '0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic        valid_o;
  logic [63:0] res_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  simd_sat_alu dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .esz_i(esz_i), .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .res_o(res_o)
  );

  function automatic logic [63:0] model(logic [3:0] op, logic [1:0] es,
                                        logic [63:0] a, logic [63:0] b);
    int w;
    logic [63:0] r;
    longint m, ua, ub, sa, sb, v, hi, lo;
    w = (es == 2'd0) ? 8 : (es == 2'd1) ? 16 : 32;
    case (op)
      4'd6: return a & b;
      4'd7: return ~a & b;
      4'd8: return a | b;
      4'd9: return a ^ b;
      default: ;
    endcase
    if (op > 4'd11) return 64'd0;
    m  = (longint'(1) << w) - 1;
    hi = (longint'(1) << (w - 1)) - 1;
    lo = -(longint'(1) << (w - 1));
    r = '0;
    for (int l = 0; l < 64 / w; l++) begin
      ua = longint'((a >> (l * w)) & 64'(m));
      ub = longint'((b >> (l * w)) & 64'(m));
      sa = ((ua >> (w - 1)) & 1) != 0 ? ua - (m + 1) : ua;
      sb = ((ub >> (w - 1)) & 1) != 0 ? ub - (m + 1) : ub;
      case (op)
        4'd0: v = ua + ub;
        4'd1: v = ua - ub;
        4'd2: begin v = sa + sb; if (v > hi) v = hi; if (v < lo) v = lo; end
        4'd3: begin v = sa - sb; if (v > hi) v = hi; if (v < lo) v = lo; end
        4'd4: begin v = ua + ub; if (v > m) v = m; end
        4'd5: begin v = ua - ub; if (v < 0) v = 0; end
        4'd10: v = (ua == ub) ? m : 0;
        default: v = (sa > sb) ? m : 0;
      endcase
      r = r | (64'(v & m) << (l * w));
    end
    return r;
  endfunction

  function automatic string req_of(logic [3:0] op);
    if (op <= 4'd1) return "R2";
    if (op <= 4'd3) return "R3";
    if (op <= 4'd5) return "R4";
    if (op <= 4'd9) return "R5";
    if (op <= 4'd11) return "R6";
    return "R7";
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // drive at a falling edge, capture on the rising edge, sample at the next falling edge
  task automatic run(string tag, logic [3:0] op, logic [1:0] es,
                     logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    op_i = op; esz_i = es; a_i = a; b_i = b; valid_i = 1'b1;
    @(negedge clk);
    check(tag, res_o, model(op, es, a, b));
    check("R8", {63'd0, valid_o}, 64'd1);
    valid_i = 1'b0;
  endtask

  function automatic logic [63:0] pick();
    case ($urandom_range(0, 5))
      0: return {8{8'h7f}};
      1: return {8{8'h80}};
      2: return {8{8'hff}};
      3: return {4{16'h7fff}} ^ {$urandom, $urandom} & 64'h0101_0101_0101_0101;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    logic [63:0] held;
    void'($urandom(32'd20250611));
    #1;
    // R10
    check("R10", res_o, 64'd0);
    check("R10", {63'd0, valid_o}, 64'd0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R10", res_o, 64'd0);
    check("R8", {63'd0, valid_o}, 64'd0);

    // R1 directed lane cuts: carry must stay inside the selected lane
    run("R1", 4'd0, 2'd0, 64'h00ff_00ff_00ff_00ff, 64'h0001_0001_0001_0001);
    run("R1", 4'd0, 2'd1, 64'h00ff_00ff_00ff_00ff, 64'h0001_0001_0001_0001);
    run("R1", 4'd0, 2'd1, 64'h0000_ffff_0000_ffff, 64'h0000_0001_0000_0001);
    run("R1", 4'd0, 2'd2, 64'h0000_ffff_0000_ffff, 64'h0000_0001_0000_0001);
    run("R1", 4'd1, 2'd3, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001);
    // R3 directed clamps
    run("R3", 4'd2, 2'd0, {8{8'h7f}}, {8{8'h01}});
    run("R3", 4'd3, 2'd1, {4{16'h8000}}, {4{16'h0001}});
    run("R3", 4'd2, 2'd2, {2{32'h8000_0000}}, {2{32'hffff_ffff}});
    // R4 directed clamps
    run("R4", 4'd4, 2'd1, {4{16'hfff0}}, {4{16'h0020}});
    run("R4", 4'd5, 2'd0, {8{8'h05}}, {8{8'h06}});
    // R5 and-not order
    run("R5", 4'd7, 2'd0, 64'hf0f0_0000_ffff_1234, 64'hffff_ffff_0000_5678);
    // R6 signed compare across sign boundary and equality
    run("R6", 4'd11, 2'd0, {8{8'h01}}, {8{8'hff}});
    run("R6", 4'd11, 2'd1, {4{16'h8000}}, {4{16'h7fff}});
    run("R6", 4'd10, 2'd2, 64'h1234_5678_0000_0001, 64'h1234_5678_0000_0002);
    // R7 unused opcodes
    run("R7", 4'd13, 2'd0, {8{8'hff}}, {8{8'h11}});

    // R9 hold: new operands with valid low must not reach res_o
    run("R2", 4'd0, 2'd0, 64'h0102_0304_0506_0708, 64'h1111_1111_1111_1111);
    held = model(4'd0, 2'd0, 64'h0102_0304_0506_0708, 64'h1111_1111_1111_1111);
    a_i = {8{8'haa}}; op_i = 4'd9;
    @(negedge clk);
    check("R9", res_o, held);
    check("R8", {63'd0, valid_o}, 64'd0);

    for (int i = 0; i < 600; i++) begin
      logic [3:0]  op;
      logic [1:0]  es;
      logic [63:0] a, b;
      op = 4'($urandom_range(0, 15));
      es = 2'($urandom_range(0, 3));
      a = pick();
      b = ($urandom_range(0, 7) == 0) ? a : pick();
      run(req_of(op), op, es, a, b);
    end
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule